// File: doc/BRIEF.md
# Link-Word to Sample Deassembler

This block takes 32-bit words from a serial link's data-link layer and turns them into a stream of 12-bit converter samples, one per frame clock. It serves a single-lane, single-converter arrangement with one sample per frame and two octets per frame. Each link word therefore holds two 16-bit containers. The low container is emitted first and the high container second. The 12-bit sample is the most significant part of each container. The four remaining bits come out as a tail field, and the lowest of them is also given as a control bit.

Both clocks are modelled in the frame-clock domain. The link layer presents a new word once every two frame cycles, and the block itself supplies the link phase. A four-state machine runs the block. `ST_RESET` is held while reset is active and moves to `ST_IDLE` on the first edge after release, which raises link-side ready. `ST_IDLE` moves to `ST_LOW` when link data is offered, and the word is latched at that point. `ST_LOW` moves to `ST_HIGH` and `ST_HIGH` moves back to `ST_LOW` (latching the next word) for as long as link valid stays high. From either of these two states, a cycle with link valid low returns the block to `ST_IDLE`. If downstream ready is low while a sample is on the output, the state and the sample are held, and link-side ready is dropped.

When the descrambler ahead of this block is enabled, the first two link words of a burst (four samples) cannot be trusted, because the descrambler starts from an unknown seed. A discard flag marks those samples.

Top module: `sample_deassembler`

## Requirements
- R1: `lnk_ready` is low while `rst_n` is low and stays low until the first rising clock edge after `rst_n` rises. From that edge on, it is high unless a stall (R8) is in progress.
- R2: When the block is idle and `lnk_valid` is high with `lnk_ready` at a clock edge, `smp_valid` goes high in the cycle after that edge.
- R3: The first sample of each link word is bits [15:4] of that word, and the second sample is bits [31:20].
- R4: `smp_tail` is the low four bits of the selected container (word bits [3:0] for the first sample, [19:16] for the second), and `smp_ctrl` equals bit 0 of that container.
- R5: If `lnk_valid` is low at an edge where no stall is in progress, `smp_valid` is low in the following cycle.
- R6: `lnk_data` is sampled only at the edge that starts the first sample of a word. Its value at the edge that moves the block to the second sample has no effect on the output.
- R7: When `scr_en` is high, `smp_discard` is high for the first four samples after each rise of `smp_valid` and low for later samples.
- R8: While `smp_valid` is high and `dn_ready` is low, `smp_data`, `smp_tail` and `smp_discard` hold their values, `smp_valid` stays high and `lnk_ready` is low. The next sample follows one cycle after `dn_ready` returns high.
- R9: When `scr_en` is low, `smp_discard` is never high.
- R10: If `lnk_valid` drops after only the first sample of a word, the second sample is dropped. The next burst starts with the low sample of the new word, and its discard window starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scr_en | input | 1 | Descrambler enabled upstream; enables discard tagging |
| lnk_valid | input | 1 | Link layer offers data |
| lnk_data | input | 32 | Link word, two 16-bit containers, low container first |
| lnk_ready | output | 1 | Block can accept link data |
| dn_ready | input | 1 | Downstream accepts the current sample |
| smp_valid | output | 1 | Output sample is valid |
| smp_data | output | 12 | Output sample, upper 12 bits of the container |
| smp_tail | output | 4 | Low 4 bits of the container |
| smp_ctrl | output | 1 | Bit 0 of the container |
| smp_discard | output | 1 | Sample should be dropped (descrambler start-up) |

## Verification
Every output comes from a register, so a value given at one edge shows up one clock later. A new link word offered at an edge appears as the low sample after that edge. The high sample comes one cycle later, and the valid drop comes one cycle after the edge where `lnk_valid` is seen low. Only `lnk_ready` reacts in the same cycle, to `dn_ready`. The bench drives every input on the falling edge and checks the outputs on the next falling edge, so each check lands exactly one register stage after its stimulus. Stalls are held for several cycles, and each of those cycles is checked for held data.

// File: rtl/deasm_pkg.sv
`timescale 1ns/1ps
package deasm_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_LOW   = 2'd2,
        ST_HIGH  = 2'd3
    } deasm_state_e;

endpackage

// File: rtl/deasm_fsm.sv
`timescale 1ns/1ps
module deasm_fsm
    import deasm_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lnk_valid,
    input  logic         dn_ready,
    output deasm_state_e state,
    output logic         lnk_ready,
    output logic         out_valid,
    output logic         sel_high,
    output logic         load,
    output logic         start,
    output logic         advance,
    output logic         drop
);

    deasm_state_e state_q;
    deasm_state_e state_d;
    logic         stall;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: state_d = ST_IDLE;
            ST_IDLE:  if (lnk_valid) state_d = ST_LOW;
            ST_LOW: begin
                if (!stall) state_d = lnk_valid ? ST_HIGH : ST_IDLE;
            end
            ST_HIGH: begin
                if (!stall) state_d = lnk_valid ? ST_LOW : ST_IDLE;
            end
            default:  state_d = ST_RESET;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = (state_q == ST_LOW) || (state_q == ST_HIGH);
        sel_high  = (state_q == ST_HIGH);
        stall     = out_valid && !dn_ready;
        lnk_ready = (state_q != ST_RESET) && !stall;
        advance   = lnk_ready && lnk_valid;
        drop      = lnk_ready && !lnk_valid && out_valid;
        start     = advance && (state_q == ST_IDLE);
        load      = advance && (state_q != ST_LOW);
    end

    assign state = state_q;

endmodule

// File: rtl/deasm_split.sv
`timescale 1ns/1ps
module deasm_split #(
    parameter int LINK_W = 32,
    parameter int CONT_W = 16,
    parameter int SMP_W  = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     sel_high,
    input  logic [LINK_W-1:0]        lnk_data,
    output logic [SMP_W-1:0]         smp_data,
    output logic [CONT_W-SMP_W-1:0]  smp_tail
);

    localparam int N_CONT = LINK_W / CONT_W;
    localparam int TAIL_W = CONT_W - SMP_W;

    logic [LINK_W-1:0] word_q;
    logic [CONT_W-1:0] cont [N_CONT];
    logic [CONT_W-1:0] chosen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load) begin
            word_q <= lnk_data;
        end
    end

    for (genvar g = 0; g < N_CONT; g++) begin : g_cont
        assign cont[g] = word_q[g*CONT_W +: CONT_W];
    end

    assign chosen   = sel_high ? cont[1] : cont[0];
    assign smp_data = chosen[CONT_W-1 -: SMP_W];
    assign smp_tail = chosen[TAIL_W-1:0];

endmodule

// File: rtl/deasm_discard.sv
`timescale 1ns/1ps
module deasm_discard #(
    parameter int N_DISC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic advance,
    input  logic drop,
    input  logic scr_en,
    output logic discard
);

    localparam int CNT_W = $clog2(N_DISC + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= CNT_W'(1);
            flag_q <= scr_en;
        end else if (advance) begin
            flag_q <= scr_en && (cnt_q < CNT_W'(N_DISC));
            if (cnt_q < CNT_W'(N_DISC)) cnt_q <= cnt_q + 1'b1;
        end else if (drop) begin
            flag_q <= 1'b0;
        end
    end

    assign discard = flag_q;

endmodule

// File: rtl/sample_deassembler.sv
`timescale 1ns/1ps
module sample_deassembler
    import deasm_pkg::*;
#(
    parameter int LINK_W = 32,
    parameter int CONT_W = 16,
    parameter int SMP_W  = 12,
    parameter int N_DISC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scr_en,
    input  logic              lnk_valid,
    input  logic [LINK_W-1:0] lnk_data,
    output logic              lnk_ready,
    input  logic              dn_ready,
    output logic              smp_valid,
    output logic [SMP_W-1:0]  smp_data,
    output logic [CONT_W-SMP_W-1:0] smp_tail,
    output logic              smp_ctrl,
    output logic              smp_discard
);

    deasm_state_e state;
    logic sel_high;
    logic load;
    logic start;
    logic advance;
    logic drop;

    deasm_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .lnk_valid (lnk_valid),
        .dn_ready  (dn_ready),
        .state     (state),
        .lnk_ready (lnk_ready),
        .out_valid (smp_valid),
        .sel_high  (sel_high),
        .load      (load),
        .start     (start),
        .advance   (advance),
        .drop      (drop)
    );

    deasm_split #(
        .LINK_W (LINK_W),
        .CONT_W (CONT_W),
        .SMP_W  (SMP_W)
    ) u_split (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .sel_high (sel_high),
        .lnk_data (lnk_data),
        .smp_data (smp_data),
        .smp_tail (smp_tail)
    );

    deasm_discard #(
        .N_DISC (N_DISC)
    ) u_disc (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .advance (advance),
        .drop    (drop),
        .scr_en  (scr_en),
        .discard (smp_discard)
    );

    assign smp_ctrl = smp_tail[0];

endmodule

// File: rtl/sample_deassembler_chk.sv
`timescale 1ns/1ps
module sample_deassembler_chk #(
    parameter int SMP_W  = 12,
    parameter int TAIL_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scr_en,
    input logic              lnk_valid,
    input logic              lnk_ready,
    input logic              dn_ready,
    input logic              smp_valid,
    input logic [SMP_W-1:0]  smp_data,
    input logic [TAIL_W-1:0] smp_tail,
    input logic              smp_discard
);

    // R1
    ready_in_reset_chk: assert property (@(posedge clk) !rst_n |-> !lnk_ready);

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_valid && lnk_ready && !smp_valid) |=> smp_valid);

    // R5
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lnk_valid && !(smp_valid && !dn_ready)) |=> !smp_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && !dn_ready) |=>
            (smp_valid && $stable(smp_data) && $stable(smp_tail) && $stable(smp_discard)));

    // R9
    discard_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smp_discard) |-> $past(scr_en));

    // R7
    discard_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_discard |-> smp_valid);

endmodule

bind sample_deassembler sample_deassembler_chk #(
    .SMP_W  (SMP_W),
    .TAIL_W (CONT_W - SMP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scr_en      (scr_en),
    .lnk_valid   (lnk_valid),
    .lnk_ready   (lnk_ready),
    .dn_ready    (dn_ready),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .smp_tail    (smp_tail),
    .smp_discard (smp_discard)
);

// File: tb/sim_sample_deassembler.sv
`timescale 1ns/1ps
module sim_sample_deassembler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scr_en = 1'b0;
    logic        lnk_valid = 1'b0;
    logic [31:0] lnk_data = '0;
    logic        lnk_ready;
    logic        dn_ready = 1'b1;
    logic        smp_valid;
    logic [11:0] smp_data;
    logic [3:0]  smp_tail;
    logic        smp_ctrl;
    logic        smp_discard;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sample_deassembler u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scr_en      (scr_en),
        .lnk_valid   (lnk_valid),
        .lnk_data    (lnk_data),
        .lnk_ready   (lnk_ready),
        .dn_ready    (dn_ready),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .smp_tail    (smp_tail),
        .smp_ctrl    (smp_ctrl),
        .smp_discard (smp_discard)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] wgen(input int seed, input int i);
        return 32'(32'h9E37_79B9 * 32'(seed * 8 + i + 1)) ^ 32'h5A5A_0F0F;
    endfunction

    // checks one output sample against the word it came from
    task automatic exp_sample(input string req, input logic [31:0] w,
                              input bit hi, input bit disc);
        logic [15:0] c;
        c = hi ? w[31:16] : w[15:0];
        chk(req, "valid", {31'd0, smp_valid}, 32'd1);
        chk(req, "data (R3)", {20'd0, smp_data}, {20'd0, c[15:4]});
        chk(req, "tail (R4)", {28'd0, smp_tail}, {28'd0, c[3:0]});
        chk(req, "ctrl (R4)", {31'd0, smp_ctrl}, {31'd0, c[0]});
        chk(req, "discard (R7/R9)", {31'd0, smp_discard}, {31'd0, disc});
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", {31'd0, lnk_ready}, 32'd0);
        chk("R1", "valid in reset", {31'd0, smp_valid}, 32'd0);
        rst_n = 1'b1;
        #1;
        chk("R1", "ready before first edge", {31'd0, lnk_ready}, 32'd0);
        @(negedge clk);
        chk("R1", "ready after first edge", {31'd0, lnk_ready}, 32'd1);
        chk("R1", "valid after reset", {31'd0, smp_valid}, 32'd0);
    endtask

    // streams nw words; second-half data replaced with junk (R6)
    task automatic t_stream(input int nw, input bit scr, input int seed);
        @(negedge clk);
        scr_en = scr;
        chk("R2", "idle before burst", {31'd0, smp_valid}, 32'd0);
        lnk_valid = 1'b1;
        lnk_data  = wgen(seed, 0);
        for (int s = 0; s < 2 * nw; s++) begin
            @(negedge clk);
            exp_sample((s == 0) ? "R2" : ((s % 2) ? "R6" : "R3"),
                       wgen(seed, s / 2), (s % 2) == 1, scr && (s < 4));
            if ((s % 2) == 0) begin
                lnk_data = ~lnk_data;
            end else if ((s / 2) + 1 < nw) begin
                lnk_data = wgen(seed, s / 2 + 1);
            end else begin
                lnk_valid = 1'b0;
            end
        end
        @(negedge clk);
        chk("R5", "valid after drop", {31'd0, smp_valid}, 32'd0);
        chk("R7", "discard after drop", {31'd0, smp_discard}, 32'd0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        scr_en    = 1'b1;
        lnk_valid = 1'b1;
        lnk_data  = wgen(5, 0);
        @(negedge clk);
        exp_sample("R8", wgen(5, 0), 1'b0, 1'b1);
        dn_ready = 1'b0;
        lnk_data = wgen(5, 7);
        #1;
        chk("R8", "ready during stall", {31'd0, lnk_ready}, 32'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            exp_sample("R8", wgen(5, 0), 1'b0, 1'b1);
            chk("R8", "ready held low", {31'd0, lnk_ready}, 32'd0);
        end
        dn_ready = 1'b1;
        #1;
        chk("R8", "ready after release", {31'd0, lnk_ready}, 32'd1);
        @(negedge clk);
        exp_sample("R8", wgen(5, 0), 1'b1, 1'b1);
        lnk_valid = 1'b0;
        @(negedge clk);
        chk("R5", "valid after stall burst", {31'd0, smp_valid}, 32'd0);
    endtask

    task automatic t_middrop;
        @(negedge clk);
        scr_en    = 1'b1;
        lnk_valid = 1'b1;
        lnk_data  = wgen(9, 0);
        @(negedge clk);
        exp_sample("R10", wgen(9, 0), 1'b0, 1'b1);
        lnk_valid = 1'b0;
        @(negedge clk);
        chk("R10", "valid after mid-word drop", {31'd0, smp_valid}, 32'd0);
        lnk_valid = 1'b1;
        lnk_data  = wgen(9, 1);
        @(negedge clk);
        exp_sample("R10", wgen(9, 1), 1'b0, 1'b1);
        lnk_data = 32'hFFFF_FFFF;
        @(negedge clk);
        exp_sample("R10", wgen(9, 1), 1'b1, 1'b1);
        lnk_valid = 1'b0;
        @(negedge clk);
        chk("R5", "valid after restart burst", {31'd0, smp_valid}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_stream(4, 1'b1, 1);
        t_stream(3, 1'b0, 2);
        t_stall();
        t_middrop();
        t_stream(1, 1'b1, 3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(4 * 50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule